// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one SMBus host transaction, described by a small set of configuration values, into an ordered series of bus primitives. The primitives are: start (with target address and direction), send byte, receive byte, master NACK and stop. The controller supplies an address byte, a protocol selector, a command byte, two data bytes and the contents of a block buffer, then pulses `go`. The sequencer walks the script that belongs to the chosen protocol. Each primitive is offered on a valid/ready handshake, so a slow bus side only stretches the transaction.

Read results go back into the two data registers, or into the block buffer for block reads. A busy flag covers the whole transaction. A done flag is raised once the stop primitive is taken. A protocol code the sequencer does not know raises an error flag, and the bus is never touched. Pin-level timing, packet error checking, interrupts and arbitration belong to the primitive consumer or are absent.

Top module: `smbus_host_seq`

## Requirements
- R1: The first primitive of every transaction is a start whose 7-bit address is bits 7:1 of `cfg_addr`. Bit 0 of `cfg_addr` is the direction, where 1 means read. Primitive codes on `prim_op` are start=0, send=1, receive=2, NACK=3 and stop=4. `prim_rd`=1 on a start means read mode.
- R2: Protocol 0 (quick) issues a start carrying the direction bit, then a stop, and nothing else.
- R3: Protocol 1 write issues start(write), send(command), stop. Protocol 1 read issues start(read), receive, NACK, stop, and the received byte lands in `res_d0`.
- R4: Protocol 2 write issues start(write), send(command), send(data0), stop. Protocol 2 read issues start(write), send(command), start(read), receive, NACK, stop, and the byte lands in `res_d0`.
- R5: Protocol 3 moves the low byte first. A write sends command, data0, data1. A read performs the same repeated start as protocol 2, receives two bytes into `res_d0` then `res_d1`, then NACK and stop.
- R6: Protocol 5 read sends the command, repeats the start in read mode and receives a length byte. A length above 32 counts as 0. That many bytes are then received into buffer entries 0 upward, followed by NACK and stop. The effective length is returned in `res_d0`.
- R7: Protocol 5 write clamps data0 to 32 to form the length. It sends command, length, then that many buffer entries from entry 0, then stop.
- R8: Protocol codes 4, 6 and 7 set `err` on the cycle after `go` and leave `busy` low. They issue no primitive.
- R9: While `prim_valid` is high and `prim_ready` low, the offered primitive (code, direction, address, data) stays unchanged.
- R10: `busy` rises on the cycle after an accepted `go` and `done` clears then. When the stop primitive is accepted, `busy` falls and `done` rises on the next cycle.
- R11: A `go` pulse while `busy` is high is ignored. Writes to the block buffer while `busy` is high are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a transaction with the cfg_* values |
| cfg_addr | input | 8 | Target address in 7:1, direction in bit 0 |
| cfg_proto | input | 3 | Protocol selector |
| cfg_cmd | input | 8 | Command byte |
| cfg_d0 | input | 8 | Data byte 0 (block write length) |
| cfg_d1 | input | 8 | Data byte 1 |
| blk_we | input | 1 | Block buffer write strobe |
| blk_widx | input | 5 | Block buffer write index |
| blk_wdata | input | 8 | Block buffer write data |
| blk_ridx | input | 5 | Block buffer read index |
| blk_rdata | output | 8 | Block buffer read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction ended with stop |
| err | output | 1 | Last go carried an unknown protocol |
| res_d0 | output | 8 | Data register 0 |
| res_d1 | output | 8 | Data register 1 |
| prim_valid | output | 1 | Primitive offered |
| prim_ready | input | 1 | Primitive accepted |
| prim_op | output | 3 | Primitive code |
| prim_rd | output | 1 | Read mode for a start |
| prim_addr | output | 7 | Target address for a start |
| prim_data | output | 8 | Byte for a send |
| prim_rx | input | 8 | Byte returned with an accepted receive |

## Verification
A wrong script state shows at the primitive port on the very next accepted handshake: a missing repeated start, an extra send or a skipped NACK alters the logged primitive sequence at once. A wrong byte counter shows in two ways. A block transfer ends early or late, which changes the number of primitives before the stop. Or read bytes land in the wrong data register or buffer entry, which is visible as soon as `done` rises. Stalls from `prim_ready` are randomised so that any state that advances without a handshake breaks the sequence or the held primitive.

// File: rtl/smbus_host_pkg.sv
// Shared codes for the SMBus host sequencer.
// Assumes primitive codes are decoded by the bus-side consumer.
package smbus_host_pkg;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_STOP  = 3'd4
    } prim_op_e;

    localparam logic [2:0] PROTO_QUICK = 3'd0;
    localparam logic [2:0] PROTO_BYTE  = 3'd1;
    localparam logic [2:0] PROTO_BDATA = 3'd2;
    localparam logic [2:0] PROTO_WORD  = 3'd3;
    localparam logic [2:0] PROTO_BLOCK = 3'd5;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ADDR, SQ_CMD, SQ_LEN, SQ_WR,
        SQ_RESTART, SQ_RLEN, SQ_RD, SQ_NACK, SQ_STOP
    } seq_st_e;

    // True for the protocol codes that have a script.
    function automatic logic proto_known(input logic [2:0] p);
        return (p == PROTO_QUICK) || (p == PROTO_BYTE) || (p == PROTO_BDATA) ||
               (p == PROTO_WORD)  || (p == PROTO_BLOCK);
    endfunction

endpackage

// File: rtl/smbus_blk_buf.sv
// Block data buffer: DEPTH bytes, one write port for the controller, one
// for the sequencer (sequencer wins), two combinational read ports.
// Assumes the caller gates controller writes during a transaction.
module smbus_blk_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [7:0]       sw_wdata,
    input  logic             sq_we,
    input  logic [IDX_W-1:0] sq_idx,
    input  logic [7:0]       sq_wdata,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [7:0]       ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [7:0]       rb_data
);

    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Per-entry storage with sequencer priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= 8'h00;
            else if (sq_we && (sq_idx == IDX_W'(i)))
                mem[i] <= sq_wdata;
            else if (sw_we && (sw_idx == IDX_W'(i)))
                mem[i] <= sw_wdata;
        end
    end

    // Combinational read ports.
    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];

endmodule

// File: rtl/smbus_seq_fsm.sv
// Primitive script walker. Holds the transaction registers and the two
// data registers, steps one state per accepted primitive.
// Assumes `launch` only arrives while idle and carries a known protocol.
module smbus_seq_fsm
    import smbus_host_pkg::*;
#(
    parameter int BLK_MAX = 32,
    parameter int IDX_W   = $clog2(BLK_MAX),
    parameter int CNT_W   = $clog2(BLK_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [7:0]       l_addr,
    input  logic [2:0]       l_proto,
    input  logic [7:0]       l_cmd,
    input  logic [7:0]       l_d0,
    input  logic [7:0]       l_d1,
    output logic             prim_valid,
    input  logic             prim_ready,
    output logic [2:0]       prim_op,
    output logic             prim_rd,
    output logic [6:0]       prim_addr,
    output logic [7:0]       prim_data,
    input  logic [7:0]       prim_rx,
    output logic             stop_fire,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic [7:0]       buf_wdata,
    input  logic [7:0]       buf_rdata,
    output logic [7:0]       d0,
    output logic [7:0]       d1
);

    seq_st_e          st;
    logic [7:0]       addr_q;
    logic [2:0]       proto_q;
    logic [7:0]       cmd_q;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             fire;
    logic             is_rd;
    logic             last_byte;
    logic [CNT_W-1:0] wr_len;
    logic [CNT_W-1:0] rx_len;
    logic [7:0]       wr_byte;

    assign is_rd     = addr_q[0];
    assign fire      = prim_valid && prim_ready;
    assign cnt_nx    = cnt_q + 1'b1;
    assign last_byte = (cnt_nx == total_q);
    assign wr_len    = (l_d0 > 8'(BLK_MAX)) ? CNT_W'(BLK_MAX) : l_d0[CNT_W-1:0];
    assign rx_len    = (prim_rx > 8'(BLK_MAX)) ? '0 : prim_rx[CNT_W-1:0];
    assign stop_fire = fire && (st == SQ_STOP);
    assign buf_idx   = cnt_q[IDX_W-1:0];
    assign buf_wdata = prim_rx;
    assign buf_we    = fire && (st == SQ_RD) && (proto_q == PROTO_BLOCK);

    // Byte source for the data phase of a write.
    always_comb begin
        case (proto_q)
            PROTO_WORD:  wr_byte = (cnt_q == '0) ? d0 : d1;
            PROTO_BLOCK: wr_byte = buf_rdata;
            default:     wr_byte = d0;
        endcase
    end

    // Primitive offered in each state.
    always_comb begin
        prim_valid = (st != SQ_IDLE);
        prim_op    = OP_STOP;
        prim_rd    = 1'b0;
        prim_addr  = addr_q[7:1];
        prim_data  = 8'h00;
        case (st)
            SQ_ADDR: begin
                prim_op = OP_START;
                prim_rd = ((proto_q == PROTO_QUICK) || (proto_q == PROTO_BYTE)) && is_rd;
            end
            SQ_CMD:     begin prim_op = OP_SEND; prim_data = cmd_q; end
            SQ_LEN:     begin prim_op = OP_SEND; prim_data = 8'(total_q); end
            SQ_WR:      begin prim_op = OP_SEND; prim_data = wr_byte; end
            SQ_RESTART: begin prim_op = OP_START; prim_rd = 1'b1; end
            SQ_RLEN:    prim_op = OP_RECV;
            SQ_RD:      prim_op = OP_RECV;
            SQ_NACK:    prim_op = OP_NACK;
            default:    prim_op = OP_STOP;
        endcase
    end

    // Script stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            addr_q  <= '0;
            proto_q <= '0;
            cmd_q   <= '0;
            total_q <= '0;
            cnt_q   <= '0;
            d0      <= '0;
            d1      <= '0;
        end else if (launch) begin
            st      <= SQ_ADDR;
            addr_q  <= l_addr;
            proto_q <= l_proto;
            cmd_q   <= l_cmd;
            d0      <= l_d0;
            d1      <= l_d1;
            cnt_q   <= '0;
            total_q <= (l_proto == PROTO_WORD)  ? CNT_W'(2) :
                       (l_proto == PROTO_BLOCK) ? wr_len : CNT_W'(1);
        end else if (fire) begin
            case (st)
                SQ_ADDR: begin
                    if (proto_q == PROTO_QUICK)              st <= SQ_STOP;
                    else if (proto_q == PROTO_BYTE && is_rd) st <= SQ_RD;
                    else                                     st <= SQ_CMD;
                end
                SQ_CMD: begin
                    if (proto_q == PROTO_BYTE)       st <= SQ_STOP;
                    else if (is_rd)                  st <= SQ_RESTART;
                    else if (proto_q == PROTO_BLOCK) st <= SQ_LEN;
                    else                             st <= SQ_WR;
                end
                SQ_LEN:     st <= (total_q == '0) ? SQ_STOP : SQ_WR;
                SQ_WR: begin
                    cnt_q <= cnt_nx;
                    if (last_byte) st <= SQ_STOP;
                end
                SQ_RESTART: st <= (proto_q == PROTO_BLOCK) ? SQ_RLEN : SQ_RD;
                SQ_RLEN: begin
                    d0      <= 8'(rx_len);
                    total_q <= rx_len;
                    cnt_q   <= '0;
                    st      <= (rx_len == '0) ? SQ_NACK : SQ_RD;
                end
                SQ_RD: begin
                    if (proto_q != PROTO_BLOCK) begin
                        if (cnt_q == '0) d0 <= prim_rx;
                        else             d1 <= prim_rx;
                    end
                    cnt_q <= cnt_nx;
                    if (last_byte) st <= SQ_NACK;
                end
                SQ_NACK:    st <= SQ_STOP;
                default:    st <= SQ_IDLE;
            endcase
        end
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid && !prim_ready |=> prim_valid && $stable(prim_op) &&
        $stable(prim_data) && $stable(prim_rd) && $stable(prim_addr)); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= CNT_W'(BLK_MAX)); // R6
    AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid && (st == SQ_LEN) |-> prim_data <= 8'(BLK_MAX)); // R7

endmodule

// File: rtl/smbus_host_seq.sv
// SMBus host transaction sequencer top: accepts go, keeps busy/done/err
// status and wires the script walker to the block buffer.
// Assumes the primitive consumer returns receive data with prim_ready.
module smbus_host_seq
    import smbus_host_pkg::*;
#(
    parameter int BLK_MAX = 32,
    parameter int IDX_W   = $clog2(BLK_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       cfg_addr,
    input  logic [2:0]       cfg_proto,
    input  logic [7:0]       cfg_cmd,
    input  logic [7:0]       cfg_d0,
    input  logic [7:0]       cfg_d1,
    input  logic             blk_we,
    input  logic [IDX_W-1:0] blk_widx,
    input  logic [7:0]       blk_wdata,
    input  logic [IDX_W-1:0] blk_ridx,
    output logic [7:0]       blk_rdata,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       res_d0,
    output logic [7:0]       res_d1,
    output logic             prim_valid,
    input  logic             prim_ready,
    output logic [2:0]       prim_op,
    output logic             prim_rd,
    output logic [6:0]       prim_addr,
    output logic [7:0]       prim_data,
    input  logic [7:0]       prim_rx
);

    localparam int CNT_W = $clog2(BLK_MAX + 1);

    logic             accept;
    logic             launch;
    logic             stop_fire;
    logic             sq_we;
    logic [IDX_W-1:0] sq_idx;
    logic [7:0]       sq_wdata;
    logic [7:0]       sq_rdata;

    assign accept = go && !busy;
    assign launch = accept && proto_known(cfg_proto);

    // Transaction status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
        end else if (accept) begin
            busy <= proto_known(cfg_proto);
            err  <= !proto_known(cfg_proto);
            done <= 1'b0;
        end else if (stop_fire) begin
            busy <= 1'b0;
            done <= 1'b1;
        end
    end

    smbus_seq_fsm #(.BLK_MAX(BLK_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .l_addr(cfg_addr), .l_proto(cfg_proto), .l_cmd(cfg_cmd),
        .l_d0(cfg_d0), .l_d1(cfg_d1),
        .prim_valid(prim_valid), .prim_ready(prim_ready), .prim_op(prim_op),
        .prim_rd(prim_rd), .prim_addr(prim_addr), .prim_data(prim_data),
        .prim_rx(prim_rx), .stop_fire(stop_fire),
        .buf_we(sq_we), .buf_idx(sq_idx), .buf_wdata(sq_wdata), .buf_rdata(sq_rdata),
        .d0(res_d0), .d1(res_d1)
    );

    smbus_blk_buf #(.DEPTH(BLK_MAX), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .sw_we(blk_we && !busy), .sw_idx(blk_widx), .sw_wdata(blk_wdata),
        .sq_we(sq_we), .sq_idx(sq_idx), .sq_wdata(sq_wdata),
        .ra_idx(sq_idx), .ra_data(sq_rdata),
        .rb_idx(blk_ridx), .rb_data(blk_rdata)
    );

    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> prim_valid && (prim_op == OP_START)); // R1
    AST_BAD_PROTO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        go && !busy && !proto_known(cfg_proto) |=> err && !busy && !prim_valid); // R8
    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid |-> busy); // R10
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid && prim_ready && (prim_op == OP_STOP) |=> done && !busy); // R10
    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go && busy && !(prim_valid && prim_ready && prim_op == OP_STOP) |=> busy && !err); // R11

endmodule

// File: tb/smbus_host_seq_bench.sv
`timescale 1ns/1ps
module smbus_host_seq_bench;

    localparam int BLK = 32;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       go = 0;
    logic [7:0] cfg_addr = 0, cfg_cmd = 0, cfg_d0 = 0, cfg_d1 = 0;
    logic [2:0] cfg_proto = 0;
    logic       blk_we = 0;
    logic [4:0] blk_widx = 0, blk_ridx = 0;
    logic [7:0] blk_wdata = 0, blk_rdata;
    logic       busy, done, err;
    logic [7:0] res_d0, res_d1;
    logic       prim_valid, prim_ready = 0, prim_rd;
    logic [2:0] prim_op;
    logic [6:0] prim_addr;
    logic [7:0] prim_data, prim_rx = 0;

    int errs = 0, checks = 0;
    bit stall_en = 0;

    logic [2:0] log_op [64];
    logic       log_rd [64];
    logic [6:0] log_ad [64];
    logic [7:0] log_dt [64];
    int         log_n = 0;
    logic [2:0] e_op [64];
    logic       e_rd [64];
    logic [6:0] e_ad [64];
    logic [7:0] e_dt [64];
    int         e_n = 0;
    logic [7:0] rx_src [64];
    int         rx_idx = 0;
    logic [7:0] tb_blk [BLK];

    always #2.5 clk = ~clk;

    smbus_host_seq u_smbus_host_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_addr(cfg_addr), .cfg_proto(cfg_proto),
        .cfg_cmd(cfg_cmd), .cfg_d0(cfg_d0), .cfg_d1(cfg_d1),
        .blk_we(blk_we), .blk_widx(blk_widx), .blk_wdata(blk_wdata),
        .blk_ridx(blk_ridx), .blk_rdata(blk_rdata),
        .busy(busy), .done(done), .err(err), .res_d0(res_d0), .res_d1(res_d1),
        .prim_valid(prim_valid), .prim_ready(prim_ready), .prim_op(prim_op),
        .prim_rd(prim_rd), .prim_addr(prim_addr), .prim_data(prim_data), .prim_rx(prim_rx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus-side responder: random ready, logs accepted primitives, checks holds.
    initial begin
        bit         held = 0;
        logic [2:0] h_op;
        logic       h_rd;
        logic [6:0] h_ad;
        logic [7:0] h_dt;
        forever begin
            @(negedge clk);
            if (held)
                chk(prim_valid && prim_op == h_op && prim_rd == h_rd &&
                    prim_addr == h_ad && prim_data == h_dt, "R9", "stalled primitive held",
                    {prim_op, prim_data}, {h_op, h_dt});
            prim_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
            held = prim_valid && !prim_ready;
            h_op = prim_op; h_rd = prim_rd; h_ad = prim_addr; h_dt = prim_data;
            if (prim_valid && prim_ready && log_n < 64) begin
                log_op[log_n] = prim_op; log_rd[log_n] = prim_rd;
                log_ad[log_n] = prim_addr; log_dt[log_n] = prim_data;
                if (prim_op == 3'd2) begin
                    prim_rx = rx_src[rx_idx];
                    rx_idx++;
                    log_dt[log_n] = prim_rx;
                end
                log_n++;
            end
        end
    end

    task automatic push(input logic [2:0] op, input logic rd, input logic [6:0] ad,
                        input logic [7:0] dt);
        e_op[e_n] = op; e_rd[e_n] = rd; e_ad[e_n] = ad; e_dt[e_n] = dt;
        e_n++;
    endtask

    function automatic int rlen();
        return (rx_src[0] > 8'd32) ? 0 : int'(rx_src[0]);
    endfunction

    // Expected primitive script, built from the requirements.
    task automatic build_exp(input logic [7:0] a, input logic [2:0] p,
                             input logic [7:0] c, input logic [7:0] d0, input logic [7:0] d1);
        logic [6:0] ad = a[7:1];
        bit rd = a[0];
        e_n = 0;
        if (p == 0) begin
            push(0, rd, ad, 0); push(4, 0, 0, 0);
        end else if (p == 1) begin
            if (rd) begin push(0, 1, ad, 0); push(2, 0, 0, 0); push(3, 0, 0, 0); end
            else begin push(0, 0, ad, 0); push(1, 0, 0, c); end
            push(4, 0, 0, 0);
        end else begin
            push(0, 0, ad, 0); push(1, 0, 0, c);
            if (rd) begin
                push(0, 1, ad, 0);
                if (p == 5) begin
                    push(2, 0, 0, 0);
                    for (int i = 0; i < rlen(); i++) push(2, 0, 0, 0);
                end else begin
                    push(2, 0, 0, 0);
                    if (p == 3) push(2, 0, 0, 0);
                end
                push(3, 0, 0, 0);
            end else if (p == 5) begin
                int wl = (d0 > 8'd32) ? 32 : int'(d0);
                push(1, 0, 0, 8'(wl));
                for (int i = 0; i < wl; i++) push(1, 0, 0, tb_blk[i]);
            end else begin
                push(1, 0, 0, d0);
                if (p == 3) push(1, 0, 0, d1);
            end
            push(4, 0, 0, 0);
        end
    endtask

    task automatic load_blk();
        for (int i = 0; i < BLK; i++) begin
            @(negedge clk);
            tb_blk[i] = 8'($urandom);
            blk_we = 1; blk_widx = 5'(i); blk_wdata = tb_blk[i];
        end
        @(negedge clk);
        blk_we = 0;
    endtask

    task automatic run_txn(input logic [7:0] a, input logic [2:0] p, input logic [7:0] c,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input string req, input bit interfere);
        int k = 0;
        bit seq_ok = 1;
        logic [7:0] e0 = d0, e1 = d1;
        log_n = 0; rx_idx = 0;
        build_exp(a, p, c, d0, d1);
        @(negedge clk);
        cfg_addr = a; cfg_proto = p; cfg_cmd = c; cfg_d0 = d0; cfg_d1 = d1; go = 1;
        @(negedge clk);
        go = 0;
        chk(busy && !done, "R10", "busy set, done cleared after go", {busy, done}, 2'b10);
        if (interfere) begin
            cfg_proto = 3'd7; go = 1; blk_we = 1; blk_widx = 0; blk_wdata = 8'hEE;
            @(negedge clk);
            go = 0; blk_we = 0;
        end
        while (!done && !err && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(done && !busy && !err, req, "transaction completed", {busy, done, err}, 3'b010);
        if (log_n != e_n) seq_ok = 0;
        for (int i = 0; i < e_n && i < log_n; i++) begin
            if (log_op[i] != e_op[i]) seq_ok = 0;
            if (e_op[i] == 0 && (log_rd[i] != e_rd[i] || log_ad[i] != e_ad[i])) seq_ok = 0;
            if (e_op[i] == 1 && log_dt[i] != e_dt[i]) seq_ok = 0;
        end
        chk(seq_ok, req, "primitive sequence (R1 start/address/direction)", log_n, e_n);
        if (a[0]) begin
            if (p == 1 || p == 2 || p == 3) e0 = rx_src[0];
            if (p == 3) e1 = rx_src[1];
            if (p == 5) e0 = 8'(rlen());
        end
        chk(res_d0 == e0 && res_d1 == e1, req, "data registers", {res_d0, res_d1}, {e0, e1});
        if (p == 5 && a[0]) begin
            for (int i = 0; i < rlen(); i++) begin
                blk_ridx = 5'(i);
                #1;
                chk(blk_rdata == rx_src[1+i], interfere ? "R11" : "R6", "block buffer entry",
                    blk_rdata, rx_src[1+i]);
            end
            for (int i = 0; i < rlen(); i++) tb_blk[i] = rx_src[1+i];
        end
    endtask

    task automatic run_bad(input logic [2:0] p);
        log_n = 0;
        @(negedge clk);
        cfg_proto = p; cfg_addr = 8'hA2; go = 1;
        @(negedge clk);
        go = 0;
        chk(err && !busy && !prim_valid, "R8", "unknown protocol flags error",
            {err, busy, prim_valid}, 3'b100);
        repeat (5) @(negedge clk);
        chk(log_n == 0, "R8", "no primitive for unknown protocol", log_n, 0);
    endtask

    task automatic fill_rx(input int len0);
        for (int i = 0; i < 64; i++) rx_src[i] = 8'($urandom);
        if (len0 >= 0) rx_src[0] = 8'(len0);
    endtask

    initial begin
        logic [2:0] plist [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !err && !prim_valid && res_d0 == 0, "R10", "reset state",
            {busy, done, err, prim_valid}, 0);
        load_blk();
        fill_rx(-1);
        run_txn(8'hA0, 0, 8'h11, 8'h22, 8'h33, "R2", 0);
        run_txn(8'hA1, 0, 8'h11, 8'h22, 8'h33, "R2", 0);
        run_txn(8'h3C, 1, 8'h5E, 8'h01, 8'h02, "R3", 0);
        fill_rx(-1);
        run_txn(8'h3D, 1, 8'h5E, 8'h01, 8'h02, "R3", 0);
        run_txn(8'h50, 2, 8'h07, 8'hC3, 8'h44, "R4", 0);
        fill_rx(-1);
        run_txn(8'h51, 2, 8'h07, 8'hC3, 8'h44, "R4", 0);
        run_txn(8'h90, 3, 8'h12, 8'h34, 8'h56, "R5", 0);
        fill_rx(-1);
        run_txn(8'h91, 3, 8'h12, 8'h34, 8'h56, "R5", 0);
        run_txn(8'hB0, 5, 8'h20, 8'd5, 8'h00, "R7", 0);
        run_txn(8'hB0, 5, 8'h20, 8'd40, 8'h00, "R7", 0);
        run_txn(8'hB0, 5, 8'h20, 8'd0, 8'h00, "R7", 0);
        fill_rx(3);  run_txn(8'hB1, 5, 8'h21, 8'h00, 8'h99, "R6", 0);
        fill_rx(32); run_txn(8'hB1, 5, 8'h21, 8'h00, 8'h99, "R6", 0);
        fill_rx(33); run_txn(8'hB1, 5, 8'h21, 8'h00, 8'h99, "R6", 0);
        fill_rx(200); run_txn(8'hB1, 5, 8'h21, 8'h00, 8'h99, "R6", 0);
        fill_rx(32); run_txn(8'hB3, 5, 8'h22, 8'h00, 8'h00, "R11", 1);
        run_bad(3'd4); run_bad(3'd6); run_bad(3'd7);
        stall_en = 1;
        for (int n = 0; n < 40; n++) begin
            logic [2:0] p = plist[$urandom_range(0, 4)];
            logic [7:0] a = 8'($urandom);
            fill_rx(p == 5 ? int'($urandom_range(0, 40)) : -1);
            run_txn(a, p, 8'($urandom), 8'($urandom_range(0, 45)), 8'($urandom),
                    (p == 0) ? "R2" : (p == 1) ? "R3" : (p == 2) ? "R4" :
                    (p == 3) ? "R5" : (a[0] ? "R6" : "R7"), 0);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule